// File: doc/BRIEF.md
# Multidrop Slave Serial Receiver with Address Filtering

This block is the receive side of an asynchronous serial port used as a slave on a shared multidrop line. A free-running oversampling enable (`os_tick`) runs at sixteen times the bit rate. It times a state machine that finds a start bit, shifts in the data bits least significant first, then takes one extra bit. That bit is an address/data tag rather than parity. A stop bit ends the character. The receiver keeps decoding whether software has enabled it or not.

When disabled, the block passes only address characters (tag 1) into a 16-entry receive queue. Data characters (tag 0) are dropped. Software reads the address, compares it with its own, and enables the receiver if it matches. From then on, every character is queued whatever its tag. Each queue entry holds the data byte and a status byte. The status byte carries the tag, a framing error, a break and an overrun indication. No parity is computed or checked. A ready flag shows that the queue holds data, and an optional interrupt output follows the ready flag when its enable is set.

Top module: `mdrop_rx`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, and `rx_ready` and `irq` are low.
- R2: A character frame on `rxd` is: a low start bit, 8 data bits least significant first, one tag bit, and a stop bit, each lasting 16 `os_tick` pulses. The start bit is checked again near its middle, and a low pulse shorter than half a bit produces no character.
- R3: While `rx_en` is low, a character with tag 1 is written into the queue and `rx_ready` goes high.
- R4: While `rx_en` is low, a character with tag 0 (and no break) is discarded: the queue does not change.
- R5: While `rx_en` is high, every character is written into the queue, whatever its tag.
- R6: Status byte layout: bit 7 is break, bit 6 is framing error, bit 5 is the received tag, bit 4 is overrun, and bits 3:0 are always 0 because no parity is checked.
- R7: A low line at the middle of the stop bit sets status bit 6. This works in both the enabled and disabled states.
- R8: A break is a character whose data bits, tag and stop bit are all low. It is queued once, with status 0xC0 and data 0x00, in either enable state. No further character is decoded until the line has returned high.
- R9: A character that would be queued while the queue holds 16 entries is dropped, and the queue contents do not change. The next character that is queued carries status bit 4 set.
- R10: `irq` is high exactly when `irq_en` is high and `rx_ready` is high.
- R11: `rd_data`/`rd_stat` show the oldest entry, and a one-cycle `rd_en` removes it. Entries come out in arrival order, and `rd_en` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receiver enable (high: keep all characters) |
| irq_en | input | 1 | Interrupt enable for the ready condition |
| rd_en | input | 1 | Pop the oldest queue entry |
| rd_data | output | 8 | Data byte of the oldest entry |
| rd_stat | output | 8 | Status byte of the oldest entry |
| rx_ready | output | 1 | Queue holds at least one entry |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the filtering decision at its edges. A data-tagged character arriving while disabled must leave `rx_ready` low. A filter that ignored the enable would queue it, and one that inverted the tag would drop addresses. A short low glitch is sent to show the mid-start check, since a receiver that started on any falling edge would queue a spurious character. A framing error and a break are sent while disabled, which catches error paths that wrongly depend on the enable or that produce a second entry during a long break. The queue is filled to sixteen and one more character is sent. A design that overwrote an entry, or lost the overrun mark, shows wrong data or a clear bit 4 on the next character read out.

// File: rtl/mdrop_rx_pkg.sv
// Package: shared types and status-byte field positions for the multidrop
// receiver. Assumes an 8-bit status byte whose positions are fixed.
package mdrop_rx_pkg;

    localparam int STAT_W   = 8;
    localparam int STAT_BRK = 7;
    localparam int STAT_FRM = 6;
    localparam int STAT_TAG = 5;
    localparam int STAT_OVR = 4;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2,
        RX_HOLD  = 2'd3
    } rx_state_e;

    // Build a status byte from the error and tag flags.
    function automatic logic [STAT_W-1:0] mk_stat(input logic brk, input logic frm,
                                                  input logic tag, input logic ovr);
        logic [STAT_W-1:0] s;
        s           = '0;
        s[STAT_BRK] = brk;
        s[STAT_FRM] = frm;
        s[STAT_TAG] = tag;
        s[STAT_OVR] = ovr;
        return s;
    endfunction

endpackage

// File: rtl/mdrop_rx_sampler.sv
// Sampler: synchronises the serial line and decodes one character per frame
// (start, DATA_W data bits LSB first, tag, stop) using an oversampling
// enable at OVS pulses per bit. Assumes the line idles high. After a low stop
// bit it waits for the line to go high before looking for a new start.
module mdrop_rx_sampler
    import mdrop_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    output logic              chr_vld,
    output logic [DATA_W-1:0] chr_data,
    output logic              chr_tag,
    output logic              chr_ferr,
    output logic              chr_brk
);

    localparam int NS = DATA_W + 2;
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(NS + 1);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [IW-1:0] NSL  = IW'(NS - 1);

    logic [1:0]    sync_q;
    logic          line;
    rx_state_e     st_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [NS-1:0] sh_q;
    logic [NS-1:0] nxt_sh;

    assign line   = sync_q[1];
    assign nxt_sh = {line, sh_q[NS-1:1]};

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Frame decoder: start check, bit sampling and character emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= RX_IDLE;
            cnt_q    <= '0;
            idx_q    <= '0;
            sh_q     <= '0;
            chr_vld  <= 1'b0;
            chr_data <= '0;
            chr_tag  <= 1'b0;
            chr_ferr <= 1'b0;
            chr_brk  <= 1'b0;
        end else begin
            chr_vld <= 1'b0;
            case (st_q)
                RX_IDLE: begin
                    if (os_tick && !line) begin
                        st_q  <= RX_START;
                        cnt_q <= CW'(1);
                    end
                end
                RX_START: begin
                    if (os_tick) begin
                        if (cnt_q == MID) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            st_q  <= line ? RX_IDLE : RX_BITS;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                RX_BITS: begin
                    if (os_tick) begin
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            sh_q  <= nxt_sh;
                            if (idx_q == NSL) begin
                                chr_vld  <= 1'b1;
                                chr_data <= nxt_sh[DATA_W-1:0];
                                chr_tag  <= nxt_sh[DATA_W];
                                chr_ferr <= !line;
                                chr_brk  <= !line && (nxt_sh[DATA_W:0] == '0);
                                st_q     <= line ? RX_IDLE : RX_HOLD;
                            end else begin
                                idx_q <= idx_q + IW'(1);
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                default: begin
                    if (line) st_q <= RX_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/mdrop_rx_accept.sv
// Accept filter: decides whether a decoded character enters the queue.
// Disabled receivers keep address-tagged characters and breaks only.
// A character that should be kept but finds the queue full is dropped and
// marks the next kept character as overrun. Assumes one-cycle chr_vld.
module mdrop_rx_accept
    import mdrop_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              chr_vld,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_tag,
    input  logic              chr_ferr,
    input  logic              chr_brk,
    input  logic              q_full,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic [STAT_W-1:0] push_stat
);

    logic keep;
    logic ovr_q;

    // Keep decision from enable state, tag and break.
    always_comb begin
        keep      = chr_vld && (rx_en || chr_tag || chr_brk);
        push      = keep && !q_full;
        push_data = chr_data;
        push_stat = mk_stat(chr_brk, chr_ferr, chr_tag, ovr_q);
    end

    // Pending overrun mark, set on a full-queue drop, cleared once reported.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovr_q <= 1'b0;
        else if (keep && q_full) ovr_q <= 1'b1;
        else if (push)           ovr_q <= 1'b0;
    end

endmodule

// File: rtl/mdrop_rx_fifo.sv
// Receive queue: DEPTH entries of W bits with a fall-through head.
// A push when full and a pop when empty are ignored. Assumes DEPTH >= 2.
module mdrop_rx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);

    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = AW + 1;
    localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

    logic [W-1:0]    mem_q [DEPTH];
    logic [AW-1:0]   wr_q, rd_q;
    logic [CNTW-1:0] cnt_q;
    logic            do_push, do_pop;

    assign full    = (cnt_q == CNT_FULL);
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[rd_q];

    // Storage write at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= wdata;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + AW'(1);
            if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNTW'(1);
                2'b01:   cnt_q <= cnt_q - CNTW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/mdrop_rx.sv
// Top: multidrop slave receiver. Chains sampler, accept filter and queue.
// The interrupt output is built only when HAS_IRQ is set.
// Assumes os_tick comes from an external baud generator at 16x the bit rate.
module mdrop_rx
    import mdrop_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OVS     = 16,
    parameter int DEPTH   = 16,
    parameter bit HAS_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              irq_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] rd_stat,
    output logic              rx_ready,
    output logic              irq
);

    localparam int EW = DATA_W + STAT_W;

    logic              chr_vld, chr_tag, chr_ferr, chr_brk;
    logic [DATA_W-1:0] chr_data;
    logic              push_w, q_full, q_empty;
    logic [DATA_W-1:0] push_data;
    logic [STAT_W-1:0] push_stat;
    logic [EW-1:0]     head;

    mdrop_rx_sampler #(.DATA_W(DATA_W), .OVS(OVS)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .rxd      (rxd),
        .chr_vld  (chr_vld),
        .chr_data (chr_data),
        .chr_tag  (chr_tag),
        .chr_ferr (chr_ferr),
        .chr_brk  (chr_brk)
    );

    mdrop_rx_accept #(.DATA_W(DATA_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .chr_vld   (chr_vld),
        .chr_data  (chr_data),
        .chr_tag   (chr_tag),
        .chr_ferr  (chr_ferr),
        .chr_brk   (chr_brk),
        .q_full    (q_full),
        .push      (push_w),
        .push_data (push_data),
        .push_stat (push_stat)
    );

    mdrop_rx_fifo #(.W(EW), .DEPTH(DEPTH)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_w),
        .wdata ({push_stat, push_data}),
        .pop   (rd_en),
        .rdata (head),
        .full  (q_full),
        .empty (q_empty)
    );

    assign rd_data  = head[DATA_W-1:0];
    assign rd_stat  = head[EW-1:DATA_W];
    assign rx_ready = !q_empty;

    // Interrupt request present only in the variant that asks for it.
    generate
        if (HAS_IRQ) begin : g_irq
            assign irq = irq_en && rx_ready;
        end else begin : g_noirq
            logic unused_irq_en;
            assign unused_irq_en = irq_en;
            assign irq = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/mdrop_rx_chk.sv
// Checker: temporal properties of the multidrop receiver, bound to the top.
module mdrop_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       chr_vld,
    input logic       chr_tag,
    input logic       chr_ferr,
    input logic       chr_brk,
    input logic       push,
    input logic [7:0] push_stat,
    input logic       full,
    input logic       empty,
    input logic       rx_ready,
    input logic       irq
);

    assert_off_keeps_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !rx_en) |-> (push_stat[5] || push_stat[7]));

    assert_ready_after_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && empty) |=> rx_ready);

    assert_drop_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !rx_en && !chr_tag && !chr_brk) |-> !push);

    assert_keep_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && rx_en && !full) |-> push);

    assert_tag_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_stat[5] == chr_tag) && (push_stat[3:0] == 4'h0));

    assert_break_frames_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && chr_brk) |-> chr_ferr);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    assert_irq_needs_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_ready);

endmodule

bind mdrop_rx mdrop_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .chr_vld   (chr_vld),
    .chr_tag   (chr_tag),
    .chr_ferr  (chr_ferr),
    .chr_brk   (chr_brk),
    .push      (push_w),
    .push_stat (push_stat),
    .full      (q_full),
    .empty     (q_empty),
    .rx_ready  (rx_ready),
    .irq       (irq)
);

// File: tb/sim_mdrop_rx.sv
// Directed bench for mdrop_rx: one task per scenario, each self-checking.
module sim_mdrop_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data, rd_stat;
    logic       rx_ready, irq;
    int         nvec = 0;
    int         nerr = 0;
    bit         done = 1'b0;

    localparam int BIT_CYC = 32; // 16 ticks, one tick every other cycle

    always #10 clk = ~clk; // 50 MHz

    // Oversampling enable on every second clock.
    always @(posedge clk) os_tick <= ~os_tick;

    mdrop_rx u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .rx_en(rx_en), .irq_en(irq_en), .rd_en(rd_en),
        .rd_data(rd_data), .rd_stat(rd_stat), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] d, input logic t, input logic stp);
        rxd = 1'b0;
        repeat (BIT_CYC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT_CYC) @(negedge clk);
        end
        rxd = t;
        repeat (BIT_CYC) @(negedge clk);
        rxd = stp;
        repeat (BIT_CYC) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
    endtask

    task automatic pop_chk(input string req, input logic [7:0] ed, input logic [7:0] es);
        chk(req, "ready", {7'd0, rx_ready}, 8'd1);
        chk(req, "data", rd_data, ed);
        chk(req, "stat", rd_stat, es);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "ready after reset", {7'd0, rx_ready}, 8'd0);
        chk("R1", "irq after reset", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_glitch_and_frame;
        rx_en = 1'b1;
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT_CYC) @(negedge clk);
        chk("R2", "glitch queued nothing", {7'd0, rx_ready}, 8'd0);
        send_char(8'hA5, 1'b0, 1'b1);
        pop_chk("R2", 8'hA5, 8'h00); // R6: no parity bits, tag 0
        send_char(8'h01, 1'b0, 1'b1);
        pop_chk("R2", 8'h01, 8'h00);
    endtask

    task automatic t_disabled_addr;
        rx_en = 1'b0;
        send_char(8'h42, 1'b1, 1'b1);
        pop_chk("R3", 8'h42, 8'h20); // R6: tag in bit 5
        chk("R3", "empty after read", {7'd0, rx_ready}, 8'd0);
    endtask

    task automatic t_disabled_data;
        rx_en = 1'b0;
        send_char(8'h17, 1'b0, 1'b1);
        chk("R4", "data char dropped", {7'd0, rx_ready}, 8'd0);
    endtask

    task automatic t_enabled_mixed;
        rx_en = 1'b1;
        send_char(8'h81, 1'b0, 1'b1);
        send_char(8'h7E, 1'b1, 1'b1);
        pop_chk("R5", 8'h81, 8'h00);
        pop_chk("R5", 8'h7E, 8'h20);
        chk("R11", "empty after two pops", {7'd0, rx_ready}, 8'd0);
    endtask

    task automatic t_framing;
        rx_en = 1'b0;
        send_char(8'h3C, 1'b1, 1'b0);
        pop_chk("R7", 8'h3C, 8'h60);
    endtask

    task automatic t_break;
        rx_en = 1'b0;
        rxd = 1'b0;
        repeat (14 * BIT_CYC) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        pop_chk("R8", 8'h00, 8'hC0);
        chk("R8", "single break entry", {7'd0, rx_ready}, 8'd0);
    endtask

    task automatic t_irq;
        rx_en = 1'b1;
        irq_en = 1'b1;
        @(negedge clk);
        chk("R10", "irq with empty queue", {7'd0, irq}, 8'd0);
        send_char(8'h11, 1'b0, 1'b1);
        chk("R10", "irq when ready", {7'd0, irq}, 8'd1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R10", "irq masked", {7'd0, irq}, 8'd0);
        pop_chk("R10", 8'h11, 8'h00);
    endtask

    task automatic t_empty_pop;
        rx_en = 1'b1;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R11", "pop on empty", {7'd0, rx_ready}, 8'd0);
        send_char(8'h99, 1'b0, 1'b1);
        pop_chk("R11", 8'h99, 8'h00);
        chk("R11", "empty again", {7'd0, rx_ready}, 8'd0);
    endtask

    task automatic t_overrun;
        rx_en = 1'b1;
        for (int i = 0; i < 16; i++) send_char(8'(i + 16), 1'b0, 1'b1);
        send_char(8'hEE, 1'b1, 1'b1);
        pop_chk("R9", 8'd16, 8'h00);
        send_char(8'h55, 1'b0, 1'b1);
        for (int i = 1; i < 16; i++) pop_chk("R9", 8'(i + 16), 8'h00);
        pop_chk("R9", 8'h55, 8'h10);
        chk("R9", "empty at end", {7'd0, rx_ready}, 8'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_glitch_and_frame();
        t_disabled_addr();
        t_disabled_data();
        t_enabled_mixed();
        t_framing();
        t_break();
        t_irq();
        t_empty_pop();
        t_overrun();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nvec++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule